// File: doc/BRIEF.md
# Banked One-Time Fuse Programming Controller

This block takes a single-word fuse program request from a simple memory-mapped register bus and plays it into a modelled array of one-time fuses as a serial sequence. Each step of the sequence burns one bit. Software loads the target address and an unlock key into the control register, places the data in the data registers, and then writes data register 0. That last write starts the operation. While the sequence runs, the data register being burned shifts right with zero fill. Every bit that is 1 produces a program strobe framed by idle gaps. Bits that are 0 are passed over in one cycle.

An elaboration parameter selects one of two addressing modes. In flat mode the address field names a single fuse word and only data register 0 is burned. In banked mode the address names a bank of four words, and data register k holds the word at offset k within that bank. The four registers are burned in order 0, 1, 2, 3, and a data register left at zero burns nothing. A read port exposes the fuse contents so they can be compared against expected values.

Top module: `otp_bank_prog`

## Requirements
- R1: After reset the control, timing and data registers all read 0. BUSY and ERROR are both clear.
- R2: The control register sits at offset 0x00. Writes there replace the address field [6:0], the reload-shadows bit [10] and the key field [31:16]. Writes to offset 0x04 OR into those fields and writes to offset 0x08 clear them. BUSY [8] and ERROR [9] cannot be written. A 1 in bit 9 of a write to 0x08 clears ERROR, and nothing else clears it.
- R3: The timing register sits at offset 0x10. In flat mode it keeps bits [21:0]: strobe [11:0], relax gap [15:12] and read strobe [21:16]. In banked mode it keeps bits [19:0]: strobe [11:0] and fuse-source gap [19:12]. All other bits read 0.
- R4: A write to data register 0 (offset 0x20) launches programming only if the key field holds 0x3E77, the block is idle and ERROR is clear. The key field reads 0 once the operation is accepted. Writes to data registers 1 to 3 (offsets 0x30, 0x40, 0x50) only load a value and never start an operation.
- R5: A write to data register 0 while the key is wrong burns nothing, leaves BUSY clear and sets ERROR.
- R6: Any data register write while BUSY is ignored and sets ERROR. A write to data register 0 while ERROR is set launches nothing.
- R7: In flat mode the burned fuse word is the one named by the address field, and it receives the bits of data register 0.
- R8: In banked mode data register k is burned into fuse word address*4+k. An address at or above the bank count is rejected with ERROR and no programming.
- R9: Burning is serial with a right shift and zero fill, so every data register involved reads 0 when the operation ends.
- R10: Each 1 bit raises the program strobe output for exactly max(strobe,1) cycles. A 0 bit raises no strobe, so the strobe count equals the popcount of the data.
- R11: Between two consecutive strobes the output stays low for at least twice the active gap count.
- R12: Fuse bits can only be set. Programming a word again ORs the new bits into it.
- R13: BUSY reads 1 from the cycle after an accepted launch until the last bit is handled, then clears without software action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| fuse_raddr | input | FA_W | Fuse array read word address |
| fuse_rdata | output | 32 | Fuse array read word |
| prog_pulse | output | 1 | Program strobe currently applied to a fuse bit |

## Verification
The assertions check a set of properties on every cycle. A strobe is only active while BUSY is set. A data write during BUSY always raises ERROR. The key is already clear on the first cycle of BUSY. ERROR falls only after a clear-alias write with bit 9 set. A watched fuse word never loses a bit. The directed scenarios show what needs whole-sequence knowledge: the fuse word that ends up burned in each mode, the bank-to-word mapping, exact strobe widths and minimum gaps for given timing values, zero data registers after an operation, and the rejection paths for a wrong key, an address out of range and writes made during an operation.

// File: rtl/otp_pkg.sv
package otp_pkg;

    localparam logic [7:0] OFS_CTRL = 8'h00;
    localparam logic [7:0] OFS_CSET = 8'h04;
    localparam logic [7:0] OFS_CCLR = 8'h08;
    localparam logic [7:0] OFS_TIME = 8'h10;
    localparam logic [7:0] OFS_DAT0 = 8'h20;
    localparam logic [7:0] OFS_DAT1 = 8'h30;
    localparam logic [7:0] OFS_DAT2 = 8'h40;
    localparam logic [7:0] OFS_DAT3 = 8'h50;

    localparam logic [15:0] UNLOCK_KEY = 16'h3E77;

    localparam int CB_BUSY   = 8;
    localparam int CB_ERR    = 9;
    localparam int CB_RELOAD = 10;

    localparam int PW_W   = 12;
    localparam int GAP_W  = 8;
    localparam int WORD_W = 32;
    localparam int BIT_W  = $clog2(WORD_W);

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_EVAL,
        SQ_PRE,
        SQ_PULSE,
        SQ_POST
    } seq_state_e;

    function automatic logic is_data_ofs(input logic [7:0] a);
        return (a == OFS_DAT0) || (a == OFS_DAT1) || (a == OFS_DAT2) || (a == OFS_DAT3);
    endfunction

endpackage

// File: rtl/otp_fuse_array.sv
module otp_fuse_array
    import otp_pkg::*;
#(
    parameter int WORDS = 64,
    localparam int FA_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [FA_W-1:0]   waddr,
    input  logic [BIT_W-1:0]  wbit,
    input  logic [FA_W-1:0]   raddr,
    output logic [WORD_W-1:0] rdata
);

    logic [WORDS-1:0][WORD_W-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (we) begin
            mem_d[waddr][wbit] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/otp_prog_seq.sv
module otp_prog_seq
    import otp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       last_word,
    input  logic [PW_W-1:0]  pw,
    input  logic [GAP_W-1:0] gap,
    input  logic             cur_bit,
    output logic             busy,
    output logic             pulse,
    output logic             shift_en,
    output logic [1:0]       word_sel,
    output logic             fuse_we,
    output logic [BIT_W-1:0] bit_idx
);

    localparam int CNT_W = (PW_W > GAP_W) ? PW_W : GAP_W;

    typedef struct packed {
        seq_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic [BIT_W-1:0] bidx;
        logic [1:0]       word;
    } seq_s;

    seq_s seq_d, seq_q;

    logic [CNT_W-1:0] pw_m1_c;
    logic [CNT_W-1:0] gap_c;
    logic             step_c;

    assign pw_m1_c = (pw == '0) ? '0 : CNT_W'(pw - 1'b1);
    assign gap_c   = CNT_W'(gap);

    always_comb begin
        seq_d    = seq_q;
        step_c   = 1'b0;
        shift_en = 1'b0;
        fuse_we  = 1'b0;
        unique case (seq_q.state)
            SQ_IDLE: begin
                if (start) begin
                    seq_d.state = SQ_EVAL;
                    seq_d.bidx  = '0;
                    seq_d.word  = '0;
                end
            end
            SQ_EVAL: begin
                if (cur_bit) begin
                    if (gap_c != '0) begin
                        seq_d.state = SQ_PRE;
                        seq_d.cnt   = gap_c;
                    end else begin
                        seq_d.state = SQ_PULSE;
                        seq_d.cnt   = pw_m1_c;
                    end
                end else begin
                    step_c = 1'b1;
                end
            end
            SQ_PRE: begin
                if (seq_q.cnt == CNT_W'(1)) begin
                    seq_d.state = SQ_PULSE;
                    seq_d.cnt   = pw_m1_c;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            SQ_PULSE: begin
                if (seq_q.cnt == '0) begin
                    fuse_we = 1'b1;
                    if (gap_c != '0) begin
                        seq_d.state = SQ_POST;
                        seq_d.cnt   = gap_c;
                    end else begin
                        step_c = 1'b1;
                    end
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            SQ_POST: begin
                if (seq_q.cnt == CNT_W'(1)) begin
                    step_c = 1'b1;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            default: seq_d.state = SQ_IDLE;
        endcase

        if (step_c) begin
            shift_en = 1'b1;
            if (seq_q.bidx == BIT_W'(WORD_W - 1)) begin
                if (seq_q.word == last_word) begin
                    seq_d.state = SQ_IDLE;
                end else begin
                    seq_d.word  = seq_q.word + 1'b1;
                    seq_d.bidx  = '0;
                    seq_d.state = SQ_EVAL;
                end
            end else begin
                seq_d.bidx  = seq_q.bidx + 1'b1;
                seq_d.state = SQ_EVAL;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{state: SQ_IDLE, cnt: '0, bidx: '0, word: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy     = (seq_q.state != SQ_IDLE);
    assign pulse    = (seq_q.state == SQ_PULSE);
    assign word_sel = seq_q.word;
    assign bit_idx  = seq_q.bidx;

endmodule

// File: rtl/otp_bank_prog.sv
module otp_bank_prog
    import otp_pkg::*;
#(
    parameter bit BANKED    = 1'b1,
    parameter int NUM_WORDS = 64,
    localparam int FA_W     = $clog2(NUM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [FA_W-1:0]   fuse_raddr,
    output logic [31:0]       fuse_rdata,
    output logic              prog_pulse
);

    localparam int          NUM_BANKS  = NUM_WORDS / 4;
    localparam int          ADDR_LIMIT = BANKED ? NUM_BANKS : NUM_WORDS;
    localparam logic [31:0] TIME_MASK  = BANKED ? 32'h000F_FFFF : 32'h003F_FFFF;
    localparam logic [1:0]  LAST_WORD  = BANKED ? 2'd3 : 2'd0;

    typedef struct packed {
        logic [6:0]              ctl_addr;
        logic                    reload;
        logic [15:0]             key;
        logic                    err;
        logic [31:0]             timing;
        logic [3:0][WORD_W-1:0]  data;
        logic [6:0]              op_addr;
    } regs_s;

    regs_s regs_d, regs_q;

    logic             seq_busy;
    logic             seq_shift;
    logic [1:0]       seq_word;
    logic             seq_fwe;
    logic [BIT_W-1:0] seq_bit;
    logic             launch_c;
    logic [GAP_W-1:0] gap_c;
    logic [FA_W-1:0]  fuse_waddr;
    logic [1:0]       didx_c;

    always_comb begin
        unique case (bus_addr)
            OFS_DAT1: didx_c = 2'd1;
            OFS_DAT2: didx_c = 2'd2;
            OFS_DAT3: didx_c = 2'd3;
            default:  didx_c = 2'd0;
        endcase
    end

    always_comb begin
        regs_d   = regs_q;
        launch_c = 1'b0;
        if (bus_wr) begin
            if (bus_addr == OFS_CTRL) begin
                regs_d.ctl_addr = bus_wdata[6:0];
                regs_d.reload   = bus_wdata[CB_RELOAD];
                regs_d.key      = bus_wdata[31:16];
            end else if (bus_addr == OFS_CSET) begin
                regs_d.ctl_addr = regs_q.ctl_addr | bus_wdata[6:0];
                regs_d.reload   = regs_q.reload | bus_wdata[CB_RELOAD];
                regs_d.key      = regs_q.key | bus_wdata[31:16];
            end else if (bus_addr == OFS_CCLR) begin
                regs_d.ctl_addr = regs_q.ctl_addr & ~bus_wdata[6:0];
                regs_d.reload   = regs_q.reload & ~bus_wdata[CB_RELOAD];
                regs_d.key      = regs_q.key & ~bus_wdata[31:16];
                if (bus_wdata[CB_ERR]) begin
                    regs_d.err = 1'b0;
                end
            end else if (bus_addr == OFS_TIME) begin
                regs_d.timing = bus_wdata & TIME_MASK;
            end else if (is_data_ofs(bus_addr)) begin
                if (seq_busy) begin
                    regs_d.err = 1'b1;
                end else if (didx_c != 2'd0) begin
                    regs_d.data[didx_c] = bus_wdata;
                end else if (!regs_q.err) begin
                    if ((regs_q.key != UNLOCK_KEY) ||
                        (int'(regs_q.ctl_addr) >= ADDR_LIMIT)) begin
                        regs_d.err = 1'b1;
                    end else begin
                        regs_d.data[0] = bus_wdata;
                        regs_d.key     = '0;
                        regs_d.op_addr = regs_q.ctl_addr;
                        launch_c       = 1'b1;
                    end
                end
            end
        end
        if (seq_shift) begin
            regs_d.data[seq_word] = {1'b0, regs_q.data[seq_word][WORD_W-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    generate
        if (BANKED) begin : g_banked
            assign gap_c      = regs_q.timing[19:12];
            assign fuse_waddr = FA_W'({regs_q.op_addr, seq_word});
        end else begin : g_flat
            assign gap_c      = {4'b0, regs_q.timing[15:12]};
            assign fuse_waddr = FA_W'(regs_q.op_addr);
        end
    endgenerate

    otp_prog_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (launch_c),
        .last_word (LAST_WORD),
        .pw        (regs_q.timing[PW_W-1:0]),
        .gap       (gap_c),
        .cur_bit   (regs_q.data[seq_word][0]),
        .busy      (seq_busy),
        .pulse     (prog_pulse),
        .shift_en  (seq_shift),
        .word_sel  (seq_word),
        .fuse_we   (seq_fwe),
        .bit_idx   (seq_bit)
    );

    otp_fuse_array #(.WORDS(NUM_WORDS)) u_fuses (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (seq_fwe),
        .waddr (fuse_waddr),
        .wbit  (seq_bit),
        .raddr (fuse_raddr),
        .rdata (fuse_rdata)
    );

    always_comb begin
        unique case (bus_addr)
            OFS_CTRL, OFS_CSET, OFS_CCLR:
                bus_rdata = {regs_q.key, 5'b0, regs_q.reload, regs_q.err,
                             seq_busy, 1'b0, regs_q.ctl_addr};
            OFS_TIME: bus_rdata = regs_q.timing;
            OFS_DAT0: bus_rdata = regs_q.data[0];
            OFS_DAT1: bus_rdata = regs_q.data[1];
            OFS_DAT2: bus_rdata = regs_q.data[2];
            OFS_DAT3: bus_rdata = regs_q.data[3];
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/otp_bank_prog_chk.sv
module otp_bank_prog_chk
    import otp_pkg::*;
#(
    parameter int FA_W = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bus_wr,
    input logic [7:0]      bus_addr,
    input logic [31:0]     bus_wdata,
    input logic            prog_pulse,
    input logic            busy,
    input logic            err,
    input logic [15:0]     key,
    input logic [FA_W-1:0] fuse_raddr,
    input logic [31:0]     fuse_rdata
);

    // R10: a strobe only exists inside an operation
    a_r10_pulse_in_op: assert property (@(posedge clk) disable iff (!rst_n)
        prog_pulse |-> busy);

    // R6: data writes during an operation raise ERROR
    a_r6_busy_write_errs: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && is_data_ofs(bus_addr) && busy) |=> err);

    // R4: key consumed on acceptance
    a_r4_key_consumed: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (key == 16'h0));

    // R2: ERROR falls only through the clear alias
    a_r2_err_clear_path: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err) |-> $past(bus_wr && (bus_addr == OFS_CCLR) && bus_wdata[CB_ERR]));

    // R12: a watched fuse word never loses a bit
    a_r12_fuse_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        (fuse_raddr == $past(fuse_raddr)) |-> (($past(fuse_rdata) & ~fuse_rdata) == 32'h0));

endmodule

bind otp_bank_prog otp_bank_prog_chk #(.FA_W(FA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .prog_pulse (prog_pulse),
    .busy       (seq_busy),
    .err        (regs_q.err),
    .key        (regs_q.key),
    .fuse_raddr (fuse_raddr),
    .fuse_rdata (fuse_rdata)
);

// File: tb/tb_otp_bank_prog.sv
module tb_otp_bank_prog;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_b = 1'b0, wr_f = 1'b0;
    logic [7:0]  addr = 8'h0;
    logic [31:0] wdata = 32'h0;
    logic [31:0] rdata_b, rdata_f;
    logic [5:0]  fra_b = 6'd0;
    logic [6:0]  fra_f = 7'd0;
    logic [31:0] frd_b, frd_f;
    logic        pulse_b, pulse_f;

    int checks = 0, fails = 0;
    bit done = 0;
    int pcnt[2], werr[2], gerr[2], hi[2], lo[2], exp_pw[2], exp_gap[2];

    always #4 clk = ~clk;

    // m = 0: banked instance, m = 1: flat instance
    otp_bank_prog #(.BANKED(1'b1), .NUM_WORDS(64)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(wr_b), .bus_addr(addr), .bus_wdata(wdata),
        .bus_rdata(rdata_b), .fuse_raddr(fra_b), .fuse_rdata(frd_b), .prog_pulse(pulse_b));

    otp_bank_prog #(.BANKED(1'b0), .NUM_WORDS(128)) dut_flat (
        .clk(clk), .rst_n(rst_n), .bus_wr(wr_f), .bus_addr(addr), .bus_wdata(wdata),
        .bus_rdata(rdata_f), .fuse_raddr(fra_f), .fuse_rdata(frd_f), .prog_pulse(pulse_f));

    always @(negedge clk) begin
        for (int m = 0; m < 2; m++) begin
            if ((m == 0) ? pulse_b : pulse_f) begin
                if (hi[m] == 0) begin
                    if (pcnt[m] > 0 && lo[m] < 2 * exp_gap[m]) gerr[m]++;
                    pcnt[m]++;
                end
                hi[m]++;
                lo[m] = 0;
            end else begin
                if (hi[m] != 0 && hi[m] != exp_pw[m]) werr[m]++;
                hi[m] = 0;
                lo[m]++;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bw(input int m, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d;
        if (m == 0) wr_b = 1'b1; else wr_f = 1'b1;
        @(negedge clk);
        wr_b = 1'b0; wr_f = 1'b0;
    endtask

    task automatic br(input int m, input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = (m == 0) ? rdata_b : rdata_f;
    endtask

    task automatic fr(input int m, input int idx, output logic [31:0] d);
        fra_b = 6'(idx); fra_f = 7'(idx);
        #1;
        d = (m == 0) ? frd_b : frd_f;
    endtask

    task automatic mon_reset(input int m, input int pw, input int gap);
        pcnt[m] = 0; werr[m] = 0; gerr[m] = 0;
        exp_pw[m] = (pw == 0) ? 1 : pw;
        exp_gap[m] = gap;
    endtask

    task automatic wait_idle(input int m);
        logic [31:0] v;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            br(m, 8'h00, v);
            if (v[8] == 1'b0) return;
        end
        chk("R13 busy never cleared", 32'h1, 32'h0);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int m = 0; m < 2; m++) begin
            br(m, 8'h00, v); chk("R1 ctrl reset", v, 32'h0);
            br(m, 8'h10, v); chk("R1 timing reset", v, 32'h0);
            br(m, 8'h20, v); chk("R1 data0 reset", v, 32'h0);
        end
    endtask

    task automatic t_aliases();
        logic [31:0] v;
        bw(0, 8'h00, 32'h0000_0405); br(0, 8'h00, v); chk("R2 ctrl write", v, 32'h0000_0405);
        bw(0, 8'h00, 32'h0000_0305); br(0, 8'h00, v); chk("R2 busy/err read-only", v, 32'h0000_0005);
        bw(0, 8'h04, 32'h0001_0400); br(0, 8'h00, v); chk("R2 set alias", v, 32'h0001_0405);
        bw(0, 8'h08, 32'h0001_0004); br(0, 8'h00, v); chk("R2 clear alias", v, 32'h0000_0401);
        bw(0, 8'h00, 32'h0);
    endtask

    task automatic t_timing_mask();
        logic [31:0] v;
        bw(0, 8'h10, 32'hFFFF_FFFF); br(0, 8'h10, v); chk("R3 banked timing mask", v, 32'h000F_FFFF);
        bw(1, 8'h10, 32'hFFFF_FFFF); br(1, 8'h10, v); chk("R3 flat timing mask", v, 32'h003F_FFFF);
    endtask

    task automatic t_flat_prog();
        logic [31:0] v;
        bw(1, 8'h10, 32'h0000_2003);
        mon_reset(1, 3, 2);
        bw(1, 8'h00, 32'h3E77_0005);
        bw(1, 8'h20, 32'h8000_0005);
        br(1, 8'h00, v); chk("R13 busy after launch", {31'b0, v[8]}, 32'h1);
        wait_idle(1);
        br(1, 8'h00, v); chk("R4 key cleared", v, 32'h0000_0005);
        fr(1, 5, v); chk("R7 flat fuse word", v, 32'h8000_0005);
        br(1, 8'h20, v); chk("R9 data0 shifted out", v, 32'h0);
        chk("R10 flat pulse count", pcnt[1], 32'd3);
        chk("R10 flat pulse width", werr[1], 32'd0);
        chk("R11 flat gap", gerr[1], 32'd0);
    endtask

    task automatic t_banked_prog();
        logic [31:0] v;
        bw(0, 8'h10, 32'h0000_1002);
        mon_reset(0, 2, 1);
        bw(0, 8'h00, 32'h3E77_0003);
        bw(0, 8'h30, 32'h0000_00F0);
        br(0, 8'h00, v); chk("R4 data1 write no launch", {31'b0, v[8]}, 32'h0);
        bw(0, 8'h40, 32'h0);
        bw(0, 8'h50, 32'h0000_0001);
        bw(0, 8'h20, 32'h0000_0100);
        wait_idle(0);
        fr(0, 12, v); chk("R8 bank word0", v, 32'h0000_0100);
        fr(0, 13, v); chk("R8 bank word1", v, 32'h0000_00F0);
        fr(0, 14, v); chk("R8 bank word2", v, 32'h0);
        fr(0, 15, v); chk("R8 bank word3", v, 32'h0000_0001);
        br(0, 8'h30, v); chk("R9 data1 shifted out", v, 32'h0);
        br(0, 8'h50, v); chk("R9 data3 shifted out", v, 32'h0);
        chk("R10 banked pulse count", pcnt[0], 32'd6);
        chk("R10 banked pulse width", werr[0], 32'd0);
        chk("R11 banked gap", gerr[0], 32'd0);
    endtask

    task automatic t_bad_key();
        logic [31:0] v;
        mon_reset(0, 2, 1);
        bw(0, 8'h00, 32'h1234_0002);
        bw(0, 8'h20, 32'h0000_00FF);
        br(0, 8'h00, v); chk("R5 no busy on bad key", {31'b0, v[8]}, 32'h0);
        chk("R5 error on bad key", {31'b0, v[9]}, 32'h1);
        fr(0, 8, v); chk("R5 fuse untouched", v, 32'h0);
        bw(0, 8'h00, 32'h3E77_0002);
        bw(0, 8'h20, 32'h0000_00FF);
        repeat (4) @(negedge clk);
        fr(0, 8, v); chk("R6 no launch while error", v, 32'h0);
        chk("R6 no pulses while error", pcnt[0], 32'd0);
        bw(0, 8'h08, 32'h0000_0200);
        br(0, 8'h00, v); chk("R2 error cleared by alias", {31'b0, v[9]}, 32'h0);
    endtask

    task automatic t_busy_reject();
        logic [31:0] v;
        bw(1, 8'h10, 32'h0000_0040);
        mon_reset(1, 64, 0);
        bw(1, 8'h00, 32'h3E77_0009);
        bw(1, 8'h20, 32'h0000_0001);
        bw(1, 8'h30, 32'h0000_AAAA);
        bw(1, 8'h20, 32'h0000_0002);
        br(1, 8'h00, v); chk("R6 error on busy write", {31'b0, v[9]}, 32'h1);
        wait_idle(1);
        fr(1, 9, v); chk("R6 busy data0 ignored", v, 32'h0000_0001);
        br(1, 8'h30, v); chk("R6 busy data1 ignored", v, 32'h0);
        chk("R10 long pulse width", werr[1], 32'd0);
        bw(1, 8'h08, 32'h0000_0200);
    endtask

    task automatic t_or_only();
        logic [31:0] v;
        bw(1, 8'h10, 32'h0);
        mon_reset(1, 0, 0);
        bw(1, 8'h00, 32'h3E77_0005);
        bw(1, 8'h20, 32'h0000_0F00);
        wait_idle(1);
        fr(1, 5, v); chk("R12 OR into programmed word", v, 32'h8000_0F05);
        chk("R10 zero strobe gives width 1", werr[1], 32'd0);
        chk("R10 popcount pulses", pcnt[1], 32'd4);
    endtask

    task automatic t_bank_range();
        logic [31:0] v;
        mon_reset(0, 2, 1);
        bw(0, 8'h00, 32'h3E77_0010);
        bw(0, 8'h20, 32'h0000_0001);
        br(0, 8'h00, v); chk("R8 out-of-range bank error", {22'b0, v[9:8]}, 32'h2);
        chk("R8 out-of-range no pulses", pcnt[0], 32'd0);
        bw(0, 8'h08, 32'h0000_0200);
    endtask

    task automatic t_zero_data();
        logic [31:0] v;
        mon_reset(1, 0, 0);
        bw(1, 8'h00, 32'h3E77_0020);
        bw(1, 8'h20, 32'h0);
        br(1, 8'h00, v); chk("R13 busy with zero data", {31'b0, v[8]}, 32'h1);
        wait_idle(1);
        chk("R10 zero data no pulses", pcnt[1], 32'd0);
        fr(1, 32, v); chk("R7 zero data word", v, 32'h0);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        for (int m = 0; m < 2; m++) begin
            pcnt[m] = 0; werr[m] = 0; gerr[m] = 0; hi[m] = 0; lo[m] = 0;
            exp_pw[m] = 1; exp_gap[m] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_aliases();
        t_timing_mask();
        t_flat_prog();
        t_banked_prog();
        t_bad_key();
        t_busy_reject();
        t_or_only();
        t_bank_range();
        t_zero_data();
        done = 1;
        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

endmodule